// File: doc/BRIEF.md
# Memory-to-Memory Byte Rotation Engine

This engine copies a block of 32-bit words from one region of a synchronous single-port memory to another. On the way it rotates every word left by one byte, so the top byte becomes the bottom byte. The block waits in an idle state until it sees a one-cycle start pulse. It then captures a source word address, a destination word address and a length in bytes. It walks the block one word at a time and raises a done flag after the last rotated word has been written.

The memory answers a read one cycle after the address is presented with write enable low. A write takes effect when address, write enable and data are presented together. The engine drives the address, write enable and write data combinationally from its state registers, so each command reaches the memory in the cycle it is meant for. Each word costs one read cycle followed by one write cycle. The rotated data is formed directly from the read-data port during the write cycle.

The controller has four states, all entered and left on the rising clock edge:
- `ST_IDLE`: reached on reset.
- `ST_READ`: issues the read of word i.
- `ST_WRITE`: writes word i back rotated.
- `ST_DONE`: holds done high.

Its transitions are:
- `IDLE/DONE -> READ` on an accepted start with a non-zero word count.
- `IDLE/DONE -> DONE` on an accepted start with a zero word count.
- `READ -> WRITE` always.
- `WRITE -> READ` while words remain.
- `WRITE -> DONE` after the last word.

Top module: `word_rotate_engine`

## Requirements
- R1: While reset is low, and in any cycle outside a running job, `done` is 0 after reset and `mem_we` is 0. No memory write happens until a start is accepted.
- R2: Every written word equals the word read for the same index with its bytes reordered as {in[23:16], in[15:8], in[7:0], in[31:24]}. For example, 0x02468ACE is written as 0x468ACE02.
- R3: Word i is read by presenting address `src_base[15:0] + i` with `mem_we` low. The data is taken from `mem_rdata` in the following cycle.
- R4: Word i is written to address `dst_base[15:0] + i`, in ascending order of i, exactly once. No write is issued outside the destination words `dst_base .. dst_base + N - 1`.
- R5: The word count N is `len_bytes` divided by 4. Bits [1:0] of `len_bytes` are ignored.
- R6: Call the rising edge that samples an accepted start edge 0. Then `done` is first high after edge 2N and stays high until the next start is accepted. It drops after the edge that accepts a new start with N > 0.
- R7: With N = 0, `done` is high after the edge that accepts start, and no memory write is issued.
- R8: A start arriving while a job is running is ignored. The running job completes with its original addresses, data and timing.
- R9: `mem_clk` follows `clk`.
- R10: Addresses are 16-bit word addresses and wrap modulo 2^16. Source word 0xFFFF is followed by source word 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a job |
| src_base | input | 32 | Source start word address (low 16 bits used) |
| len_bytes | input | 32 | Job length in bytes (multiple of 4) |
| dst_base | input | 32 | Destination start word address (low 16 bits used) |
| done | output | 1 | High when the last word is written, until the next start |
| mem_clk | output | 1 | Memory clock, equal to clk |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after the read address |

## Verification
A wrong state or index register in this engine shows up at the memory port within one or two cycles. Such faults include:
- a write landing one word off its target;
- a write issued on two cycles in a row;
- a write carrying the previous word's data.

The bench catches these by comparing the destination region against rotated source words and by checking guard words on either side. A wrong word counter or last-word decision appears as a shifted `done` edge, and the bench measures it against the exact 2N+1 sample count. Faults that affect only a busy-start or a zero-length job appear as a changed write count or a changed completion time.

// File: rtl/rot_pkg.sv
package rot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } rot_state_e;

endpackage

// File: rtl/rot_lane_rotator.sv
module rot_lane_rotator #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] word_o
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    // Output lane l takes input lane l-1; lane 0 takes the top lane.
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        localparam int SRC_LANE = (l + NUM_LANES - 1) % NUM_LANES;
        assign word_o[l*LANE_W +: LANE_W] = word_i[SRC_LANE*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/rot_word_counter.sv
module rot_word_counter #(
    parameter int CNT_W = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] total,
    output logic [CNT_W-1:0] idx,
    output logic             last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clear) begin
            idx <= '0;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    assign last = (idx == total - 1'b1);

endmodule

// File: rtl/word_rotate_engine.sv
module word_rotate_engine #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 32,
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTRL_W-1:0] src_base,
    input  logic [CTRL_W-1:0] len_bytes,
    input  logic [CTRL_W-1:0] dst_base,
    output logic              done,
    output logic              mem_clk,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import rot_pkg::*;

    localparam int BYTE_SHIFT = $clog2(DATA_W / 8);
    localparam int CNT_W      = CTRL_W - BYTE_SHIFT;

    rot_state_e        state, state_nx;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  total_q;
    logic [CNT_W-1:0]  words_in;
    logic [CNT_W-1:0]  idx;
    logic              last;
    logic              accept;
    logic              busy;
    logic [DATA_W-1:0] rot_word;
    logic              unused_ctrl_bits;

    assign mem_clk  = clk;
    assign words_in = len_bytes[CTRL_W-1:BYTE_SHIFT];
    assign busy     = (state == ST_READ) || (state == ST_WRITE);
    assign accept   = start && !busy;
    assign unused_ctrl_bits = ^{len_bytes[BYTE_SHIFT-1:0],
                                src_base[CTRL_W-1:ADDR_W], dst_base[CTRL_W-1:ADDR_W]};

    rot_word_counter #(.CNT_W(CNT_W)) i_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  ((state == ST_WRITE) && !last),
        .total (total_q),
        .idx   (idx),
        .last  (last)
    );

    rot_lane_rotator #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_rotator (
        .word_i (mem_rdata),
        .word_o (rot_word)
    );

    // Next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept) state_nx = (words_in == '0) ? ST_DONE : ST_READ;
            end
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = last ? ST_DONE : ST_READ;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // State register and job parameters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            src_q   <= '0;
            dst_q   <= '0;
            total_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                src_q   <= src_base[ADDR_W-1:0];
                dst_q   <= dst_base[ADDR_W-1:0];
                total_q <= words_in;
            end
        end
    end

    // Memory and status outputs, combinational from state
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = rot_word;
        done      = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  mem_addr = src_q + ADDR_W'(idx);
            ST_WRITE: begin
                mem_addr = dst_q + ADDR_W'(idx);
                mem_we   = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    p_quiet_outside_job_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    p_rotated_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({mem_wdata[LANE_W-1:0], mem_wdata[DATA_W-1:LANE_W]} == mem_rdata));

    p_read_before_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_write_index_matches_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr - dst_q) == ($past(mem_addr) - src_q)));

    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(src_q) && $stable(dst_q) && $stable(total_q)));

endmodule

// File: tb/test_word_rotate_engine.sv
`timescale 1ns/1ps
module test_word_rotate_engine;

    localparam int MEM_DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_base = '0, len_bytes = '0, dst_base = '0;
    logic        done, mem_clk, mem_we;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;

    logic [31:0] mem [MEM_DEPTH];
    int          wr_count = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    word_rotate_engine i_word_rotate_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .len_bytes(len_bytes), .dst_base(dst_base), .done(done),
        .mem_clk(mem_clk), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Synchronous single-port memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            if (rst_n) wr_count++;
        end
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // Job table: source, destination, length in bytes
    localparam logic [95:0] JOBS [4] = '{
        {32'd0,   32'd100, 32'd64},
        {32'd10,  32'd300, 32'd4},
        {32'd500, 32'd40,  32'd28},
        {32'd700, 32'd800, 32'd23}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rot_exp(input logic [31:0] w);
        return {w[23:16], w[15:8], w[7:0], w[31:24]};
    endfunction

    function automatic logic [31:0] pattern(input int seed);
        return {8'(seed * 5 + 1), 8'(seed + 8'h46), 8'(seed ^ 8'h8A), 8'(seed * 3 + 8'hCE)};
    endfunction

    function automatic int ix(input logic [31:0] a);
        return int'(a[9:0]);
    endfunction

    task automatic fill(input logic [31:0] src, input logic [31:0] dst, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            mem[ix(src + i)] = pattern(seed + i);
            mem[ix(dst + i)] = 32'h0;
        end
        mem[ix(dst - 1)] = 32'hDEADBEEF;
        mem[ix(dst + n)] = 32'hDEADBEEF;
    endtask

    // Starts a job, returns the number of negedge samples until done is seen.
    task automatic run_job(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] len,
                           input int poke_at, output int cycles);
        cycles = 0;
        @(negedge clk);
        src_base = src; dst_base = dst; len_bytes = len; start = 1'b1;
        @(posedge clk);
        forever begin
            @(negedge clk);
            start = 1'b0;
            cycles++;
            if (cycles == poke_at) begin
                src_base = 32'd900; dst_base = 32'd950; len_bytes = 32'd8; start = 1'b1;
            end
            if (done || cycles > 5000) break;
        end
        start = 1'b0;
    endtask

    task automatic check_job(input string req, input logic [31:0] src, input logic [31:0] dst,
                             input int n, input int seed);
        for (int i = 0; i < n; i++)
            chk(mem[ix(dst + i)] == rot_exp(pattern(seed + i)), req, mem[ix(dst + i)], rot_exp(pattern(seed + i)));
        chk(mem[ix(dst - 1)] == 32'hDEADBEEF, "R4 guard below", mem[ix(dst - 1)], 32'hDEADBEEF);
        chk(mem[ix(dst + n)] == 32'hDEADBEEF, "R4 guard above", mem[ix(dst + n)], 32'hDEADBEEF);
    endtask

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int cyc, w0, n;
        for (int i = 0; i < MEM_DEPTH; i++) mem[i] = 32'h0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 0);
        chk(mem_we == 1'b0, "R1 we in reset", 32'(mem_we), 0);
        rst_n = 1'b1;
        w0 = wr_count;
        repeat (5) @(negedge clk);
        chk(wr_count == w0, "R1 no write while idle", wr_count, w0);
        chk(done == 1'b0, "R1 done idle", 32'(done), 0);
        // R9: memory clock follows block clock
        chk(mem_clk == clk, "R9 mem_clk low phase", 32'(mem_clk), 32'(clk));
        @(posedge clk); #1;
        chk(mem_clk == clk, "R9 mem_clk high phase", 32'(mem_clk), 32'(clk));

        // Table walk: R2, R3, R4, R5, R6
        foreach (JOBS[j]) begin
            n = int'(JOBS[j][31:2]);
            fill(JOBS[j][95:64], JOBS[j][63:32], n, j * 20);
            w0 = wr_count;
            run_job(JOBS[j][95:64], JOBS[j][63:32], JOBS[j][31:0], -1, cyc);
            chk(cyc == 2 * n + 1, "R6 done timing", cyc, 2 * n + 1);
            chk(wr_count - w0 == n, "R5 write count", wr_count - w0, n);
            check_job("R2 R3 rotated word", JOBS[j][95:64], JOBS[j][63:32], n, j * 20);
        end

        // R6: done holds, then drops after a new start
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R6 done held", 32'(done), 1);
        start = 1'b1; src_base = 32'd0; dst_base = 32'd200; len_bytes = 32'd8;
        fill(32'd0, 32'd200, 2, 0);
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R6 done drops on start", 32'(done), 0);
        repeat (6) @(negedge clk);
        check_job("R6 restart job", 32'd0, 32'd200, 2, 0);

        // R7: zero length
        w0 = wr_count;
        run_job(32'd50, 32'd60, 32'd0, -1, cyc);
        chk(cyc == 1, "R7 zero-length done", cyc, 1);
        chk(wr_count == w0, "R7 no writes", wr_count - w0, 0);

        // R8: start while busy is ignored
        fill(32'd400, 32'd450, 6, 77);
        mem[ix(32'd949)] = 32'h11111111;
        mem[ix(32'd950)] = 32'h11111111;
        w0 = wr_count;
        run_job(32'd400, 32'd450, 32'd24, 4, cyc);
        chk(cyc == 13, "R8 timing unchanged", cyc, 13);
        chk(wr_count - w0 == 6, "R8 write count", wr_count - w0, 6);
        chk(mem[ix(32'd950)] == 32'h11111111, "R8 no second job", mem[ix(32'd950)], 32'h11111111);
        check_job("R8 original job", 32'd400, 32'd450, 6, 77);

        // R10: address wrap at 16 bits
        fill(32'h0001_FFFE, 32'd600, 4, 33);
        run_job(32'h0001_FFFE, 32'd600, 32'd16, -1, cyc);
        chk(cyc == 9, "R10 timing", cyc, 9);
        check_job("R10 wrapped source", 32'h0001_FFFE, 32'd600, 4, 33);

        // R1: reset mid-job returns to idle
        run_job(32'd0, 32'd100, 32'd64, 3, cyc);
        @(negedge clk);
        start = 1'b1; src_base = 32'd0; dst_base = 32'd100; len_bytes = 32'd64;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(mem_we == 1'b0, "R1 we after reset", 32'(mem_we), 0);
        chk(done == 1'b0, "R1 done after reset", 32'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        w0 = wr_count;
        repeat (4) @(negedge clk);
        chk(wr_count == w0, "R1 idle after reset", wr_count - w0, 0);

        report();
    end

endmodule